// File: doc/BRIEF.md
# Repetitive Compare-Match Timer

This block is a periodic tick source. A free-running up-counter advances once per system clock while the timer runs and is compared every cycle against a programmable compare value. On equality the block latches a sticky interrupt flag. It can optionally send the counter back to zero on the following cycle, so that the tick period is the compare value plus one. To obtain a period of N clocks, software loads N-1 into the compare register and writes zero into the counter.

Software reaches three registers over a synchronous bus. Each write takes effect on the clock edge at which the write enable is high. Read data is a combinational function of the address and the stored state. The interrupt output is the flag gated by the run state.

The run control is a two-state machine. In `ST_STOPPED` the counter holds its value. The transition START, which is a control write with the run bit set, moves it to `ST_RUNNING`. In `ST_RUNNING` the counter advances, and the transition STOP, which is a control write with the run bit clear, returns it to `ST_STOPPED`. On each edge the counter datapath takes exactly one action, chosen in this priority order: LOAD (bus write to the counter), then RESTART (match while clear-on-match is set), then STEP (running), then HOLD.

Top module: `rtick_timer`

## Requirements
- R1: After reset the compare register, the control register and the counter all read 0, and `irq` is 0.
- R2: Register map by address: 0 is the compare value (read/write); 1 is control, with bit 0 = flag, bit 1 = clear-on-match and bit 3 = run, and all other bits reading 0; 2 is the counter (read/write); 3 reads 0.
- R3: While the run bit is 0 the counter keeps its value.
- R4: While the run bit is 1 the counter increases by one on every clock edge.
- R5: With clear-on-match set, a running counter equal to the compare value becomes 0 on the next edge, giving a period of compare+1 clocks.
- R6: A match while running sets the flag on that edge, and the flag then stays set until software clears it.
- R7: Writing control with bit 0 = 1 clears the flag, while writing bit 0 = 0 leaves it unchanged.
- R8: When a match and a flag-clearing write fall on the same edge, the flag stays set.
- R9: `irq` is 1 exactly when the flag is set and the run bit is 1.
- R10: With clear-on-match clear, the counter continues past the compare value, still sets the flag on the match, and wraps from all ones to 0.
- R11: A bus write to the counter takes priority over counting and restart on that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; the counter runs at this rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Register address |
| bus_wdata | input | CNT_W | Write data |
| bus_we | input | 1 | Write enable, sampled on the rising edge |
| bus_rdata | output | CNT_W | Read data for `bus_addr` |
| irq | output | 1 | Interrupt request, which is the flag gated by the run bit |

## Verification
The bench builds the block with its defaults: a 32-bit counter (CNT_W = 32) and a 2-bit address (ADDR_W = 2). A full-width count would never wrap within a short run. A direct counter load of 32'hFFFF_FFFE brings the all-ones-to-zero wrap of R10 within three cycles. A compare value of 5 keeps several restart periods short, so the bench can land a match and a flag-clearing write on the same edge and check that the match wins.

// File: rtl/rtick_pkg.sv
package rtick_pkg;

    // register selection decoded from the bus address
    typedef enum logic [1:0] {
        SEL_CMP  = 2'd0,
        SEL_CTRL = 2'd1,
        SEL_CNT  = 2'd2,
        SEL_NONE = 2'd3
    } reg_sel_e;

    // control word bit positions
    localparam int FLAG_BIT = 0;
    localparam int WRAP_BIT = 1;
    localparam int RUN_BIT  = 3;

    typedef enum logic {
        ST_STOPPED = 1'b0,
        ST_RUNNING = 1'b1
    } run_state_e;

    typedef enum logic [1:0] {
        ACT_HOLD    = 2'd0,
        ACT_STEP    = 2'd1,
        ACT_RESTART = 2'd2,
        ACT_LOAD    = 2'd3
    } cnt_act_e;

endpackage

// File: rtl/rtick_decode.sv
module rtick_decode
    import rtick_pkg::*;
#(
    parameter int ADDR_W = 2
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              we,
    output reg_sel_e          sel,
    output logic              wr_cmp,
    output logic              wr_ctrl,
    output logic              wr_cnt
);

    logic upper_clear;

    generate
        if (ADDR_W > 2) begin : g_upper
            assign upper_clear = ~|addr[ADDR_W-1:2];
        end else begin : g_exact
            assign upper_clear = 1'b1;
        end
    endgenerate

    always_comb begin
        sel = upper_clear ? reg_sel_e'(addr[1:0]) : SEL_NONE;
    end

    assign wr_cmp  = we && (sel == SEL_CMP);
    assign wr_ctrl = we && (sel == SEL_CTRL);
    assign wr_cnt  = we && (sel == SEL_CNT);

endmodule

// File: rtl/rtick_ctrl.sv
module rtick_ctrl
    import rtick_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic wr_ctrl,
    input  logic set_run,
    input  logic set_wrap,
    input  logic clr_flag,
    input  logic at_match,
    output logic running,
    output logic wrap_en,
    output logic flag,
    output logic irq
);

    run_state_e state_q, state_d;
    logic       wrap_q, wrap_d;
    logic       flag_q, flag_d;

    // next-state decision: START and STOP transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_STOPPED: if (wr_ctrl && set_run)  state_d = ST_RUNNING; // START
            ST_RUNNING: if (wr_ctrl && !set_run) state_d = ST_STOPPED; // STOP
            default:    state_d = ST_STOPPED;
        endcase
    end

    // outputs and side state
    always_comb begin
        wrap_d = wr_ctrl ? set_wrap : wrap_q;
        flag_d = flag_q;
        if (state_q == ST_RUNNING && at_match) begin
            flag_d = 1'b1;               // match beats a clearing write
        end else if (wr_ctrl && clr_flag) begin
            flag_d = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_STOPPED;
            wrap_q  <= 1'b0;
            flag_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            wrap_q  <= wrap_d;
            flag_q  <= flag_d;
        end
    end

    assign running = (state_q == ST_RUNNING);
    assign wrap_en = wrap_q;
    assign flag    = flag_q;
    assign irq     = flag_q && running;

    // R6: a match while running sets the flag
    a_r6_flag_on_match: assert property (@(posedge clk) disable iff (!rst_n)
        running && at_match |=> flag_q);

    // R6: flag is sticky without a clearing write
    a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        flag_q && !(wr_ctrl && clr_flag) |=> flag_q);

    // R7: write-one-to-clear
    a_r7_w1c: assert property (@(posedge clk) disable iff (!rst_n)
        !(running && at_match) && wr_ctrl && clr_flag |=> !flag_q);

    // R8: simultaneous match and clear keeps the flag
    a_r8_match_wins: assert property (@(posedge clk) disable iff (!rst_n)
        running && at_match && wr_ctrl && clr_flag |=> flag_q);

    // R9: stopping the timer silences the interrupt
    a_r9_stop_silences: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ctrl && !set_run |=> !irq);

endmodule

// File: rtl/rtick_count.sv
module rtick_count
    import rtick_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_cmp,
    input  logic             wr_cnt,
    input  logic [CNT_W-1:0] wdata,
    input  logic             running,
    input  logic             wrap_en,
    output logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cmp,
    output logic             at_match
);

    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cmp_q;
    cnt_act_e         act;

    assign at_match = (cnt_q == cmp_q);

    // pick one action per edge, LOAD first
    always_comb begin
        if (wr_cnt)                               act = ACT_LOAD;
        else if (running && at_match && wrap_en)  act = ACT_RESTART;
        else if (running)                         act = ACT_STEP;
        else                                      act = ACT_HOLD;
    end

    always_comb begin
        cnt_d = cnt_q;
        unique case (act)
            ACT_LOAD:    cnt_d = wdata;
            ACT_RESTART: cnt_d = '0;
            ACT_STEP:    cnt_d = cnt_q + ONE;
            ACT_HOLD:    cnt_d = cnt_q;
            default:     cnt_d = cnt_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cmp_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            if (wr_cmp) cmp_q <= wdata;
        end
    end

    assign cnt = cnt_q;
    assign cmp = cmp_q;

    // R3: stopped counter holds
    a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !running && !wr_cnt |=> $stable(cnt_q));

    // R4 / R10: running counter steps by one, wrapping at full width
    a_r4_step: assert property (@(posedge clk) disable iff (!rst_n)
        running && !(at_match && wrap_en) && !wr_cnt |=> cnt_q == $past(cnt_q) + ONE);

    // R5: restart after a match
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        running && at_match && wrap_en && !wr_cnt |=> cnt_q == '0);

    // R11: bus load wins
    a_r11_load: assert property (@(posedge clk) disable iff (!rst_n)
        wr_cnt |=> cnt_q == $past(wdata));

endmodule

// File: rtl/rtick_timer.sv
module rtick_timer
    import rtick_pkg::*;
#(
    parameter int CNT_W  = 32,
    parameter int ADDR_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    input  logic              bus_we,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic              irq
);

    reg_sel_e         sel;
    logic             wr_cmp, wr_ctrl, wr_cnt;
    logic             running, wrap_en, flag, at_match;
    logic [CNT_W-1:0] cnt, cmp, ctrl_word;

    rtick_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr    (bus_addr),
        .we      (bus_we),
        .sel     (sel),
        .wr_cmp  (wr_cmp),
        .wr_ctrl (wr_ctrl),
        .wr_cnt  (wr_cnt)
    );

    rtick_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_ctrl  (wr_ctrl),
        .set_run  (bus_wdata[RUN_BIT]),
        .set_wrap (bus_wdata[WRAP_BIT]),
        .clr_flag (bus_wdata[FLAG_BIT]),
        .at_match (at_match),
        .running  (running),
        .wrap_en  (wrap_en),
        .flag     (flag),
        .irq      (irq)
    );

    rtick_count #(.CNT_W(CNT_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_cmp   (wr_cmp),
        .wr_cnt   (wr_cnt),
        .wdata    (bus_wdata),
        .running  (running),
        .wrap_en  (wrap_en),
        .cnt      (cnt),
        .cmp      (cmp),
        .at_match (at_match)
    );

    always_comb begin
        ctrl_word           = '0;
        ctrl_word[FLAG_BIT] = flag;
        ctrl_word[WRAP_BIT] = wrap_en;
        ctrl_word[RUN_BIT]  = running;
    end

    // R2: read mux
    always_comb begin
        unique case (sel)
            SEL_CMP:  bus_rdata = cmp;
            SEL_CTRL: bus_rdata = ctrl_word;
            SEL_CNT:  bus_rdata = cnt;
            SEL_NONE: bus_rdata = '0;
            default:  bus_rdata = '0;
        endcase
    end

    // R1: interrupt is low on the first cycle after reset
    a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !irq);

endmodule

// File: tb/sim_rtick_timer.sv
module sim_rtick_timer;
    localparam int CLK_P = 10;
    localparam int CW    = 32;
    localparam int AW    = 2;
    localparam int IRQ_SEL = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [CW-1:0] bus_wdata = '0;
    logic          bus_we = 1'b0;
    logic [CW-1:0] bus_rdata;
    logic          irq;

    typedef struct {
        int          sel;
        logic [CW-1:0] val;
        string       tag;
    } exp_t;

    exp_t q[$];
    int   total = 0;
    int   bad = 0;
    bit   done = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    rtick_timer #(.CNT_W(CW), .ADDR_W(AW)) u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_we    (bus_we),
        .bus_rdata (bus_rdata),
        .irq       (irq)
    );

    // monitor: samples a quarter period after each falling edge
    initial begin
        forever begin
            exp_t          e;
            logic [CW-1:0] act;
            @(negedge clk);
            #(CLK_P/4);
            if (q.size() > 0) begin
                e = q.pop_front();
                act = (e.sel == IRQ_SEL) ? {{(CW-1){1'b0}}, irq} : bus_rdata;
                total++;
                if (act !== e.val) begin
                    bad++;
                    $display("FAIL %s actual=%h expected=%h", e.tag, act, e.val);
                end
            end
        end
    end

    // driver: queue an expectation for this cycle
    task automatic chk(input int sel, input logic [CW-1:0] v, input string tag);
        exp_t e;
        if (sel != IRQ_SEL) bus_addr = AW'(sel);
        e.sel = sel;
        e.val = v;
        e.tag = tag;
        q.push_back(e);
        @(negedge clk);
    endtask

    task automatic wr(input int a, input logic [CW-1:0] d);
        bus_addr  = AW'(a);
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk(0, 0, "R1 compare after reset");
        chk(1, 0, "R1 control after reset");
        chk(2, 0, "R1 counter after reset");
        chk(IRQ_SEL, 0, "R1 irq after reset");
        chk(3, 0, "R2 unmapped address");
        // R2 map, R3 hold
        wr(0, 5);
        chk(0, 5, "R2 compare readback");
        wr(1, 32'hFFFF_FFF6);
        chk(1, 32'h2, "R2 control unused bits read 0");
        tick(2);
        chk(2, 0, "R3 stopped counter holds");
        // start with clear-on-match
        wr(1, 32'hA);
        chk(2, 0, "R4 count at start");
        chk(2, 1, "R4 step");
        chk(2, 2, "R4 step");
        tick(2);
        chk(2, 5, "R5 reaches compare");
        chk(2, 0, "R5 restart to zero");
        chk(1, 32'hB, "R6 flag set on match");
        chk(IRQ_SEL, 1, "R9 irq with flag and run");
        wr(1, 32'hA);
        chk(1, 32'hB, "R7 writing 0 keeps flag");
        wr(1, 32'hB);               // lands on the match edge
        chk(1, 32'hB, "R8 match beats clear");
        wr(1, 32'hB);
        chk(1, 32'hA, "R7 write 1 clears flag");
        chk(IRQ_SEL, 0, "R9 irq low without flag");
        tick(2);
        wr(1, 32'h2);               // stop, flag kept
        chk(IRQ_SEL, 0, "R9 irq gated by run bit");
        chk(1, 32'h3, "R6 flag kept while stopped");
        chk(2, 1, "R3 counter frozen");
        wr(2, 100);
        chk(2, 100, "R11 counter load while stopped");
        wr(0, 1000);
        wr(1, 32'hB);
        wr(2, 40);
        chk(2, 40, "R11 load beats counting");
        // no clear-on-match
        wr(1, 32'h8);
        wr(0, 44);
        chk(2, 43, "R10 counting");
        chk(2, 44, "R10 at compare");
        chk(2, 45, "R10 passes compare");
        chk(1, 32'h9, "R10 flag set without restart");
        wr(2, 32'hFFFF_FFFE);
        chk(2, 32'hFFFF_FFFE, "R10 near top");
        chk(2, 32'hFFFF_FFFF, "R10 all ones");
        chk(2, 0, "R10 full-width wrap");
        @(negedge clk);
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule